// File: doc/BRIEF.md
# Up/Down Timer with Reload and Capture Registers

This block is a 16-bit core counter that steps up or down by one on each tick of a coded prescaler. It is paired with a set of auxiliary registers, two by default. Each auxiliary register watches its own external trigger pin through a sampling synchroniser. On the selected edge of that pin, the register does one of two things, chosen per register:

- It copies the core value into itself (capture).
- It forces the core to its own value (reload).

There are three request flags: one per auxiliary register plus one for the core. The core flag is raised when the core wraps in either direction. An auxiliary register's flag is raised when that register acts on its trigger.

Each flag drives an interrupt output through its own enable bit. Software clears a flag with a one-cycle clear pulse. Software can also write an auxiliary register directly, so that a reload value can be set up. The prescaler, direction, run enable, modes and edge selects are static configuration inputs.

Top module: `tmr_aux_core`

## Requirements
- R1: During and after synchronous reset, the core value, every auxiliary value, every request flag and every interrupt output are zero.
- R2: While `run_en` is high, the core changes by one on every prescaler tick, and never between ticks. The tick period in clock cycles follows `psc_sel`: 01 gives 8, 00 gives 16, 11 gives 32 and 10 gives 64. The first change comes exactly one period after `run_en` rises.
- R3: With `count_down` low, a tick at 0xFFFF takes the core to 0x0000 and sets flag bit 0.
- R4: With `count_down` high, the core decrements. A tick at 0x0000 takes it to 0xFFFF and sets flag bit 0.
- R5: With `run_en` low, the core holds its value and the prescaler restarts from zero. Captures still take place.
- R6: When `aux_mode` bit i is 0 (capture), a selected edge on `trig_pin[i]` copies the core value into auxiliary register i and sets flag bit i+1. If a count tick lands in the same cycle, the captured value is the one from before that tick.
- R7: When `aux_mode` bit i is 1 (reload), a selected edge loads the core from auxiliary register i and sets flag bit i+1, but not flag bit 0. A reload overrides a count tick in the same cycle. If several reloads coincide, the lowest index wins.
- R8: Trigger pins pass through two sampling flops, and an edge is seen when two successive samples differ. The resulting action becomes visible after the third rising clock edge following the pin change, and not after the second.
- R9: `irq_out` bit k is high only while flag bit k and `irq_en` bit k are both high. A high `irq_clr` bit k clears flag bit k on the next edge, unless a new set of that flag arrives in the same cycle, in which case the set wins.
- R10: `aux_wr[i]` writes `aux_wdata` into auxiliary register i on the next edge. A capture in the same cycle takes precedence over the write.
- R11: `edge_sel[2i+1:2i]` selects the trigger edge for register i: 00 off, 01 rising only, 10 falling only, 11 both. An unselected edge changes no register and no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Basic clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Core count enable |
| count_down | input | 1 | 1 = decrement, 0 = increment, used on each tick |
| psc_sel | input | 2 | Prescaler code |
| aux_mode | input | NAUX | Per register: 0 capture, 1 reload |
| edge_sel | input | 2*NAUX | Per register trigger edge select |
| trig_pin | input | NAUX | External trigger pins |
| aux_wr | input | NAUX | Auxiliary register write strobes |
| aux_wdata | input | W | Auxiliary write data |
| irq_en | input | NAUX+1 | Interrupt enables (bit 0 core, bit i+1 register i) |
| irq_clr | input | NAUX+1 | Write-one-to-clear pulses for the flags |
| core_val | output | W | Core counter value |
| aux_val | output | NAUX*W | Auxiliary register values, register i at bits i*W+W-1:i*W |
| irq_flag | output | NAUX+1 | Request flags |
| irq_out | output | NAUX+1 | Enabled interrupt requests |

## Verification
The bench lines up a trigger edge with a prescaler tick in the same cycle. A design that let the count win would end a reload one off, and a design that captured after counting would store the incremented value. It checks the trigger latency one edge early, which exposes a missing or extra synchroniser stage. It also checks both wrap directions, which would catch a design that flags on the wrong boundary or flags on a reload. Coinciding reloads, a capture racing a software write, a set racing a clear, and each edge-select code with its ignored edge are all checked at the ports.

// File: rtl/tmr_aux_pkg.sv
package tmr_aux_pkg;

    // Largest prescaler shift; the divider counter needs one bit more.
    localparam int unsigned PSC_MAX_SHIFT = 6;
    localparam int unsigned PSC_CW        = PSC_MAX_SHIFT + 1;

    typedef enum logic [1:0] {
        EDGE_OFF  = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_sel_e;

    typedef enum logic {
        AUX_CAPTURE = 1'b0,
        AUX_RELOAD  = 1'b1
    } aux_mode_e;

    // Coded prescaler: returns log2 of the tick period in clocks.
    function automatic int unsigned psc_shift(input logic [1:0] code);
        case (code)
            2'b01:   return 3;
            2'b00:   return 4;
            2'b11:   return 5;
            default: return PSC_MAX_SHIFT;
        endcase
    endfunction

endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale
    import tmr_aux_pkg::*;
#(
    parameter int unsigned CW = PSC_CW
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       run_en,
    input  logic [1:0] sel,
    output logic       tick
);
    logic [CW-1:0] cnt;
    logic [CW-1:0] lim;

    assign lim  = CW'((1 << psc_shift(sel)) - 1);
    assign tick = run_en && (cnt >= lim);

    always_ff @(posedge clk) begin
        if (rst || !run_en) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/tmr_trig_detect.sv
module tmr_trig_detect
    import tmr_aux_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      pin,
    input  edge_sel_e sel,
    output logic      ev
);
    // smp[0], smp[1]: synchroniser; smp[2]: previous sample for comparison
    logic [2:0] smp;
    logic       rise;
    logic       fall;

    always_ff @(posedge clk) begin
        if (rst) begin
            smp <= '0;
        end else begin
            smp <= {smp[1:0], pin};
        end
    end

    assign rise = smp[1] & ~smp[2];
    assign fall = ~smp[1] & smp[2];

    always_comb begin
        case (sel)
            EDGE_RISE: ev = rise;
            EDGE_FALL: ev = fall;
            EDGE_BOTH: ev = rise | fall;
            default:   ev = 1'b0;
        endcase
    end
endmodule

// File: rtl/tmr_core_cnt.sv
module tmr_core_cnt #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         down,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    output logic [W-1:0] cnt,
    output logic         wrap
);
    localparam logic [W-1:0] TOP = '1;

    // A load masks the boundary crossing of a tick in the same cycle.
    assign wrap = tick && !ld && (down ? (cnt == '0) : (cnt == TOP));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (ld) begin
            cnt <= ld_val;
        end else if (tick) begin
            cnt <= down ? cnt - 1'b1 : cnt + 1'b1;
        end
    end
endmodule

// File: rtl/tmr_aux_reg.sv
module tmr_aux_reg #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cap,
    input  logic [W-1:0] cap_val,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] val
);
    always_ff @(posedge clk) begin
        if (rst) begin
            val <= '0;
        end else if (cap) begin
            val <= cap_val;
        end else if (wr) begin
            val <= wdata;
        end
    end
endmodule

// File: rtl/tmr_req_flags.sv
module tmr_req_flags #(
    parameter int unsigned N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    input  logic [N-1:0] en,
    output logic [N-1:0] flag,
    output logic [N-1:0] irq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= '0;
        end else begin
            flag <= (flag & ~clr) | set;
        end
    end

    assign irq = flag & en;
endmodule

// File: rtl/tmr_aux_core.sv
module tmr_aux_core
    import tmr_aux_pkg::*;
#(
    parameter int unsigned W    = 16,
    parameter int unsigned NAUX = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                run_en,
    input  logic                count_down,
    input  logic [1:0]          psc_sel,
    input  logic [NAUX-1:0]     aux_mode,
    input  logic [2*NAUX-1:0]   edge_sel,
    input  logic [NAUX-1:0]     trig_pin,
    input  logic [NAUX-1:0]     aux_wr,
    input  logic [W-1:0]        aux_wdata,
    input  logic [NAUX:0]       irq_en,
    input  logic [NAUX:0]       irq_clr,
    output logic [W-1:0]        core_val,
    output logic [NAUX*W-1:0]   aux_val,
    output logic [NAUX:0]       irq_flag,
    output logic [NAUX:0]       irq_out
);
    localparam int unsigned NFLAG = NAUX + 1;

    logic                tick;
    logic [NAUX-1:0]     trig_ev;
    logic [W-1:0]        aux_q [NAUX];
    logic                rl_hit;
    logic [W-1:0]        rl_val;
    logic                core_wrap;
    logic [NFLAG-1:0]    flag_set;

    tmr_prescale u_psc (
        .clk    (clk),
        .rst    (rst),
        .run_en (run_en),
        .sel    (psc_sel),
        .tick   (tick)
    );

    for (genvar gi = 0; gi < NAUX; gi++) begin : g_aux
        logic cap_i;

        tmr_trig_detect u_trig (
            .clk (clk),
            .rst (rst),
            .pin (trig_pin[gi]),
            .sel (edge_sel_e'(edge_sel[2*gi +: 2])),
            .ev  (trig_ev[gi])
        );

        assign cap_i = trig_ev[gi] && (aux_mode_e'(aux_mode[gi]) == AUX_CAPTURE);

        tmr_aux_reg #(.W(W)) u_reg (
            .clk     (clk),
            .rst     (rst),
            .cap     (cap_i),
            .cap_val (core_val),
            .wr      (aux_wr[gi]),
            .wdata   (aux_wdata),
            .val     (aux_q[gi])
        );

        assign aux_val[gi*W +: W] = aux_q[gi];
    end

    // Lowest-indexed reload source takes the core.
    always_comb begin
        rl_hit = 1'b0;
        rl_val = '0;
        for (int i = 0; i < NAUX; i++) begin
            if (!rl_hit && trig_ev[i] && (aux_mode_e'(aux_mode[i]) == AUX_RELOAD)) begin
                rl_hit = 1'b1;
                rl_val = aux_q[i];
            end
        end
    end

    tmr_core_cnt #(.W(W)) u_core (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .down   (count_down),
        .ld     (rl_hit),
        .ld_val (rl_val),
        .cnt    (core_val),
        .wrap   (core_wrap)
    );

    assign flag_set = {trig_ev, core_wrap};

    tmr_req_flags #(.N(NFLAG)) u_flags (
        .clk  (clk),
        .rst  (rst),
        .set  (flag_set),
        .clr  (irq_clr),
        .en   (irq_en),
        .flag (irq_flag),
        .irq  (irq_out)
    );
endmodule

// File: rtl/tmr_aux_chk.sv
module tmr_aux_chk #(
    parameter int unsigned W    = 16,
    parameter int unsigned NAUX = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              run_en,
    input logic              count_down,
    input logic              tick,
    input logic [NAUX-1:0]   trig_ev,
    input logic [NAUX-1:0]   aux_mode,
    input logic [W-1:0]      core_val,
    input logic [NAUX*W-1:0] aux_val,
    input logic [NAUX:0]     irq_flag,
    input logic [NAUX:0]     irq_en,
    input logic [NAUX:0]     irq_out
);
    logic any_reload;
    assign any_reload = |(trig_ev & aux_mode);

    assert_step_up_R2: assert property (@(posedge clk) disable iff (rst)
        tick && !count_down && !any_reload && (core_val != '1)
        |=> core_val == W'($past(core_val) + 1'b1));

    assert_up_wrap_R3: assert property (@(posedge clk) disable iff (rst)
        tick && !count_down && !any_reload && (core_val == '1)
        |=> (core_val == '0) && irq_flag[0]);

    assert_down_wrap_R4: assert property (@(posedge clk) disable iff (rst)
        tick && count_down && !any_reload && (core_val == '0)
        |=> (core_val == '1) && irq_flag[0]);

    assert_freeze_R5: assert property (@(posedge clk) disable iff (rst)
        !run_en && !any_reload |=> $stable(core_val));

    assert_capture_R6: assert property (@(posedge clk) disable iff (rst)
        trig_ev[0] && !aux_mode[0]
        |=> (aux_val[W-1:0] == $past(core_val)) && irq_flag[1]);

    assert_reload_R7: assert property (@(posedge clk) disable iff (rst)
        trig_ev[0] && aux_mode[0]
        |=> (core_val == $past(aux_val[W-1:0])) && irq_flag[1]);

    assert_irq_gate_R9: assert property (@(posedge clk) disable iff (rst)
        !irq_flag[0] || !irq_en[0] |-> !irq_out[0]);

    assert_irq_fire_R9: assert property (@(posedge clk) disable iff (rst)
        irq_flag[0] && irq_en[0] |-> irq_out[0]);
endmodule

bind tmr_aux_core tmr_aux_chk #(.W(W), .NAUX(NAUX)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .run_en     (run_en),
    .count_down (count_down),
    .tick       (tick),
    .trig_ev    (trig_ev),
    .aux_mode   (aux_mode),
    .core_val   (core_val),
    .aux_val    (aux_val),
    .irq_flag   (irq_flag),
    .irq_en     (irq_en),
    .irq_out    (irq_out)
);

// File: tb/sim_tmr_aux_core.sv
`timescale 1ns/1ps
module sim_tmr_aux_core;
    localparam int W    = 16;
    localparam int NAUX = 2;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              run_en = 1'b0;
    logic              count_down = 1'b0;
    logic [1:0]        psc_sel = 2'b01;
    logic [NAUX-1:0]   aux_mode = '0;
    logic [2*NAUX-1:0] edge_sel = '0;
    logic [NAUX-1:0]   trig_pin = '0;
    logic [NAUX-1:0]   aux_wr = '0;
    logic [W-1:0]      aux_wdata = '0;
    logic [NAUX:0]     irq_en = '0;
    logic [NAUX:0]     irq_clr = '0;
    logic [W-1:0]      core_val;
    logic [NAUX*W-1:0] aux_val;
    logic [NAUX:0]     irq_flag;
    logic [NAUX:0]     irq_out;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    tmr_aux_core #(.W(W), .NAUX(NAUX)) u0 (
        .clk(clk), .rst(rst), .run_en(run_en), .count_down(count_down),
        .psc_sel(psc_sel), .aux_mode(aux_mode), .edge_sel(edge_sel),
        .trig_pin(trig_pin), .aux_wr(aux_wr), .aux_wdata(aux_wdata),
        .irq_en(irq_en), .irq_clr(irq_clr), .core_val(core_val),
        .aux_val(aux_val), .irq_flag(irq_flag), .irq_out(irq_out)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [W-1:0] auxv(input int i);
        return aux_val[i*W +: W];
    endfunction

    task automatic wr_aux(input int i, input logic [W-1:0] v);
        aux_wr[i] = 1'b1;
        aux_wdata = v;
        step(1);
        aux_wr    = '0;
    endtask

    task automatic clr_flags();
        irq_clr = '1;
        step(1);
        irq_clr = '0;
    endtask

    task automatic t_reset();
        irq_en = '1;
        step(3);
        chk("R1", "core during reset", core_val, 0);
        rst = 1'b0;
        step(1);
        chk("R1", "core after reset", core_val, 0);
        chk("R1", "aux after reset", aux_val, 0);
        chk("R1", "flags after reset", irq_flag, 0);
        chk("R1", "irq after reset", irq_out, 0);
        irq_en = '0;
    endtask

    task automatic t_prescale();
        logic [1:0] codes [4] = '{2'b01, 2'b00, 2'b11, 2'b10};
        int         divs  [4] = '{8, 16, 32, 64};
        for (int k = 0; k < 4; k++) begin
            logic [W-1:0] base;
            base    = core_val;
            psc_sel = codes[k];
            run_en  = 1'b1;
            step(3 * divs[k] - 1);
            chk("R2", "count one cycle before third tick", core_val, base + 2);
            step(1);
            chk("R2", "count at third tick", core_val, base + 3);
            run_en = 1'b0;
        end
    endtask

    task automatic t_freeze_capture();
        // core holds 12 here
        step(50);
        chk("R5", "core frozen", core_val, 12);
        aux_mode[1]     = 1'b0;
        edge_sel[3:2]   = 2'b01;
        trig_pin[1]     = 1'b1;
        step(2);
        chk("R8", "no capture after two edges", auxv(1), 0);
        step(1);
        chk("R5", "capture while frozen", auxv(1), 12);
        chk("R6", "capture flag", irq_flag[2], 1);
        chk("R6", "capture leaves core", core_val, 12);
        irq_clr = 3'b100;
        step(1);
        irq_clr = '0;
        chk("R9", "flag cleared", irq_flag[2], 0);
    endtask

    task automatic t_edge_modes();
        wr_aux(1, 16'h1234);
        chk("R10", "aux write", auxv(1), 16'h1234);
        edge_sel[3:2] = 2'b10;
        trig_pin[1]   = 1'b0;
        step(3);
        chk("R11", "falling edge captures", auxv(1), 12);
        clr_flags();
        wr_aux(1, 16'h1234);
        trig_pin[1] = 1'b1;
        step(3);
        chk("R11", "rising ignored in fall mode", auxv(1), 16'h1234);
        chk("R11", "no flag on ignored edge", irq_flag, 0);
        edge_sel[3:2] = 2'b11;
        trig_pin[1]   = 1'b0;
        step(3);
        chk("R11", "both: falling captures", auxv(1), 12);
        wr_aux(1, 16'h1234);
        trig_pin[1] = 1'b1;
        step(3);
        chk("R11", "both: rising captures", auxv(1), 12);
        clr_flags();
        wr_aux(1, 16'h1234);
        edge_sel[3:2] = 2'b00;
        trig_pin[1]   = 1'b0;
        step(3);
        chk("R11", "off ignores pin", auxv(1), 16'h1234);
        chk("R11", "off sets no flag", irq_flag, 0);
    endtask

    task automatic t_reload_up_wrap();
        aux_mode[0]   = 1'b1;
        edge_sel[1:0] = 2'b01;
        wr_aux(0, 16'hFFFE);
        trig_pin[0] = 1'b1;
        step(3);
        chk("R7", "reload value", core_val, 16'hFFFE);
        chk("R7", "reload flag", irq_flag[1], 1);
        chk("R7", "reload no core flag", irq_flag[0], 0);
        trig_pin[0] = 1'b0;
        clr_flags();
        psc_sel    = 2'b01;
        count_down = 1'b0;
        run_en     = 1'b1;
        step(8);
        chk("R3", "reach top", core_val, 16'hFFFF);
        chk("R3", "no flag before wrap", irq_flag[0], 0);
        step(8);
        run_en = 1'b0;
        chk("R3", "wrap to zero", core_val, 0);
        chk("R3", "wrap flag", irq_flag[0], 1);
        chk("R9", "irq masked", irq_out[0], 0);
        irq_en[0] = 1'b1;
        #1;
        chk("R9", "irq enabled", irq_out[0], 1);
        irq_clr[0] = 1'b1;
        step(1);
        irq_clr = '0;
        chk("R9", "clear flag", irq_flag[0], 0);
        chk("R9", "irq after clear", irq_out[0], 0);
        irq_en = '0;
        clr_flags();
    endtask

    task automatic t_down();
        count_down = 1'b1;
        run_en     = 1'b1;
        step(8);
        chk("R4", "down wrap value", core_val, 16'hFFFF);
        chk("R4", "down wrap flag", irq_flag[0], 1);
        step(8);
        run_en = 1'b0;
        chk("R4", "down step", core_val, 16'hFFFE);
        count_down = 1'b0;
        clr_flags();
    endtask

    task automatic t_coincide();
        // Reload landing on a tick: reload wins.
        wr_aux(0, 16'h0100);
        run_en = 1'b1;
        step(5);
        trig_pin[0] = 1'b1;
        step(3);
        chk("R7", "reload beats tick", core_val, 16'h0100);
        chk("R7", "no wrap flag on reload", irq_flag[0], 0);
        step(8);
        chk("R2", "count after reload", core_val, 16'h0101);
        run_en = 1'b0;
        clr_flags();
        // Capture landing on a tick, racing a write and a clear.
        edge_sel[3:2] = 2'b01;
        run_en = 1'b1;
        step(5);
        trig_pin[1] = 1'b1;
        step(2);
        aux_wr[1] = 1'b1;
        aux_wdata = 16'hBEEF;
        irq_clr   = 3'b100;
        step(1);
        aux_wr  = '0;
        irq_clr = '0;
        chk("R6", "capture takes pre-count value", auxv(1), 16'h0101);
        chk("R10", "capture beats write", auxv(1), 16'h0101);
        chk("R9", "set beats clear", irq_flag[2], 1);
        chk("R2", "tick still counts", core_val, 16'h0102);
        run_en = 1'b0;
        clr_flags();
    endtask

    task automatic t_priority();
        aux_mode = 2'b11;
        edge_sel = 4'b0101;
        trig_pin = 2'b00;
        step(3);
        clr_flags();
        wr_aux(0, 16'h0AAA);
        wr_aux(1, 16'h0555);
        trig_pin = 2'b11;
        step(3);
        chk("R7", "lowest index reload wins", core_val, 16'h0AAA);
        chk("R7", "both flags set", irq_flag[2:1], 2'b11);
        trig_pin = 2'b00;
        edge_sel = 4'b0100;
        step(3);
        trig_pin = 2'b11;
        step(3);
        chk("R7", "second register reloads alone", core_val, 16'h0555);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_prescale();
        t_freeze_capture();
        t_edge_modes();
        t_reload_up_wrap();
        t_down();
        t_coincide();
        t_priority();
        finish_run();
    end
endmodule